// File: doc/BRIEF.md
# Multiply, Divide and Normalize Unit

This block is a sequential arithmetic extension for a 12-bit processor. It keeps a 24-bit register pair formed by the accumulator (AC, high half) and the multiplier-quotient register (MQ, low half), a one-bit link and a 5-bit step counter. A command is accepted by a one-clock `start` strobe together with a 4-bit command code and a 12-bit operand. The operand is the multiplicand, the divisor, the shift count or a value to load, depending on the command. The block works on it for one or more clocks and then raises `done` for exactly one clock. On that clock AC, MQ, link and step counter already hold the result.

The control is one state machine with seven states. IDLE waits for `start` and, on accepting it, latches the command and operand. It then branches: register moves and unknown codes go to MOVE, multiply to MUL, divide to DIV, normalize to NORM and the three shifts to SHIFT. MOVE lasts one clock. MUL and DIV run one shift-and-add or shift-and-subtract step per clock for 12 clocks. DIV leaves after its first step when it overflows. NORM loops until the top two AC bits differ or the pair is zero. SHIFT loops until the step counter reaches zero. Every working state ends in FINISH, which drives `done` and returns to IDLE on the next clock.

Bit numbering is LSB-0 throughout: AC[11] is the sign bit and the pair is {AC, MQ} with MQ[0] as its least significant bit.

Top module: `mdn_unit`

## Requirements
- R1: While `rst_n` is low and after its release, AC, MQ, link and step counter are all zero and `done` is low.
- R2: Command 0 loads AC from the operand. Command 2 copies MQ into AC with MQ kept. Command 3 loads AC with the step counter zero-extended. Each raises `done` one clock after the edge that accepts `start`, and leaves the other registers unchanged.
- R3: Command 1 copies AC into MQ and clears AC; `done` comes one clock after acceptance.
- R4: Command 4 multiplies MQ by the operand as unsigned numbers. It leaves the 24-bit product high half in AC and low half in MQ, discards the old AC, and raises `done` 12 clocks after acceptance.
- R5: Command 5 without overflow divides the unsigned 24-bit {AC, MQ} by the operand. It leaves the quotient in MQ, the remainder (less than the divisor) in AC and link 0, and raises `done` 12 clocks after acceptance.
- R6: Command 5 overflows when AC is greater than or equal to the divisor (a zero divisor included). It then sets link to 1, leaves AC and MQ unchanged and raises `done` one clock after acceptance.
- R7: Command 6 (normalize) shifts {AC, MQ} left, with zeros entering MQ[0], until AC[11] differs from AC[10]. It clears the link, leaves the number of shifts in the step counter and raises `done` shifts+1 clocks after acceptance.
- R8: Normalize of an all-zero pair stops at once with step counter 0 and `done` one clock after acceptance.
- R9: Command 7 shifts {AC, MQ} left by operand[4:0]+1 places with zeros entering; the higher operand bits are ignored. The link is unchanged, the step counter ends at 0 and `done` comes operand[4:0]+1 clocks after acceptance.
- R10: Command 8 shifts {AC, MQ} right by operand[4:0]+1 places filling with the sign bit; command 9 does the same filling with zeros. Bits leaving MQ[0] are lost, the link is unchanged, the step counter ends at 0 and the latency is as in R9.
- R11: A `start` pulse while a command is running is ignored: the running command's result and latency are unaffected and no second command follows.
- R12: `done` is high for exactly one clock per command. Codes 10 to 15 change no register and give `done` one clock after acceptance. No register changes in IDLE without `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a command (taken only in IDLE) |
| cmd | input | 4 | Command code, see R2 to R12 |
| operand | input | 12 | Multiplicand, divisor, shift count or load value |
| ac | output | 12 | Accumulator, high half of the pair |
| mq | output | 12 | Multiplier-quotient register, low half |
| link | output | 1 | Link bit; divide overflow flag |
| sc | output | 5 | Step counter |
| done | output | 1 | One-clock completion strobe |

## Verification
A wrong step count inside MUL or DIV shows at `done` as a latency other than 12 clocks, and at AC/MQ as a product or quotient off by a factor of two. A missed overflow check gives a changed AC/MQ and link 0 after one clock, where AC/MQ should be unchanged and link 1. A wrong NORM stop condition leaves a step counter value and an AC top-bit pair that disagree with the input pattern. A corrupted latched command shows as the wrong shift fill or direction. Every such fault is visible on the single clock where `done` is high, so each command is compared right there, and latency is compared with the expected count.

// File: rtl/mdn_pkg.sv
package mdn_pkg;

    localparam int unsigned WORD_W = 12;
    localparam int unsigned STEP_W = 5;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LDA = 4'd0,
        OP_MQL = 4'd1,
        OP_MQA = 4'd2,
        OP_SCA = 4'd3,
        OP_MUL = 4'd4,
        OP_DIV = 4'd5,
        OP_NMI = 4'd6,
        OP_SHL = 4'd7,
        OP_ASR = 4'd8,
        OP_LSR = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MOVE,
        ST_MUL,
        ST_DIV,
        ST_NORM,
        ST_SHIFT,
        ST_FINISH
    } st_e;

endpackage

// File: rtl/mdn_fsm.sv
module mdn_fsm
    import mdn_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  cmd,
    input  logic div_ovf,
    input  logic norm_stop,
    input  logic shift_last,
    output st_e  state,
    output logic first_step,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    st_e             state_q;
    st_e             state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_MUL || state_q == ST_DIV) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    case (cmd)
                        OP_MUL:                 state_d = ST_MUL;
                        OP_DIV:                 state_d = ST_DIV;
                        OP_NMI:                 state_d = ST_NORM;
                        OP_SHL, OP_ASR, OP_LSR: state_d = ST_SHIFT;
                        default:                state_d = ST_MOVE;
                    endcase
                end
            end
            ST_MOVE: state_d = ST_FINISH;
            ST_MUL: begin
                if (cnt_q == LAST_STEP) state_d = ST_FINISH;
            end
            ST_DIV: begin
                if ((cnt_q == '0) && div_ovf) state_d = ST_FINISH;
                else if (cnt_q == LAST_STEP)  state_d = ST_FINISH;
            end
            ST_NORM: begin
                if (norm_stop) state_d = ST_FINISH;
            end
            ST_SHIFT: begin
                if (shift_last) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state      = state_q;
        first_step = (cnt_q == '0);
        done       = (state_q == ST_FINISH);
    end

endmodule

// File: rtl/mdn_alu.sv
module mdn_alu #(
    parameter int unsigned W  = 12,
    parameter int unsigned SW = 5
) (
    input  logic [W-1:0]   ac,
    input  logic [W-1:0]   mq,
    input  logic [W-1:0]   opnd,
    input  logic [SW-1:0]  sc,
    output logic [W-1:0]   mul_ac,
    output logic [W-1:0]   mul_mq,
    output logic [W-1:0]   div_ac,
    output logic [W-1:0]   div_mq,
    output logic           div_ovf,
    output logic [2*W-1:0] shl_pair,
    output logic [2*W-1:0] asr_pair,
    output logic [2*W-1:0] lsr_pair,
    output logic           norm_stop,
    output logic           shift_last
);

    localparam int unsigned PW = 2 * W;

    logic [W:0]    mul_sum;
    logic [W:0]    div_rem;
    logic [W-1:0]  div_diff;
    logic          div_ge;
    logic [PW-1:0] pair;

    // one shift-and-add multiply step: add multiplicand when MQ lsb set
    always_comb begin
        mul_sum = {1'b0, ac} + (mq[0] ? {1'b0, opnd} : {(W+1){1'b0}});
        mul_ac  = mul_sum[W:1];
        mul_mq  = {mul_sum[0], mq[W-1:1]};
    end

    // one restoring-divide step: partial remainder stays below divisor
    always_comb begin
        div_ovf  = (ac >= opnd);
        div_rem  = {ac, mq[W-1]};
        div_ge   = (div_rem >= {1'b0, opnd});
        div_diff = div_rem[W-1:0] - opnd;
        div_ac   = div_ge ? div_diff : div_rem[W-1:0];
        div_mq   = {mq[W-2:0], div_ge};
    end

    // single-place shifts of the pair
    always_comb begin
        pair     = {ac, mq};
        shl_pair = {pair[PW-2:0], 1'b0};
        asr_pair = {pair[PW-1], pair[PW-1:1]};
        lsr_pair = {1'b0, pair[PW-1:1]};
    end

    always_comb begin
        norm_stop  = (ac[W-1] != ac[W-2]) || (pair == '0);
        shift_last = (sc == '0);
    end

endmodule

// File: rtl/mdn_regs.sv
module mdn_regs
    import mdn_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned SW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  op_e            cmd,
    input  logic [W-1:0]   operand,
    input  st_e            state,
    input  logic           first_step,
    input  logic [W-1:0]   mul_ac,
    input  logic [W-1:0]   mul_mq,
    input  logic [W-1:0]   div_ac,
    input  logic [W-1:0]   div_mq,
    input  logic           div_ovf,
    input  logic [2*W-1:0] shl_pair,
    input  logic [2*W-1:0] asr_pair,
    input  logic [2*W-1:0] lsr_pair,
    input  logic           norm_stop,
    output logic [W-1:0]   ac,
    output logic [W-1:0]   mq,
    output logic           link,
    output logic [SW-1:0]  sc,
    output op_e            cmd_q,
    output logic [W-1:0]   opnd_q
);

    localparam int unsigned PAD_W = W - SW;

    logic [W-1:0]  ac_q;
    logic [W-1:0]  mq_q;
    logic          link_q;
    logic [SW-1:0] sc_q;
    op_e           cmd_r;
    logic [W-1:0]  opnd_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q   <= '0;
            mq_q   <= '0;
            link_q <= 1'b0;
            sc_q   <= '0;
            cmd_r  <= OP_LDA;
            opnd_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_r  <= cmd;
                        opnd_r <= operand;
                        case (cmd)
                            OP_MUL: ac_q <= '0;
                            OP_NMI: begin
                                sc_q   <= '0;
                                link_q <= 1'b0;
                            end
                            OP_SHL, OP_ASR, OP_LSR: sc_q <= operand[SW-1:0];
                            default: ;
                        endcase
                    end
                end
                ST_MOVE: begin
                    case (cmd_r)
                        OP_LDA: ac_q <= opnd_r;
                        OP_MQL: begin
                            mq_q <= ac_q;
                            ac_q <= '0;
                        end
                        OP_MQA: ac_q <= mq_q;
                        OP_SCA: ac_q <= {{PAD_W{1'b0}}, sc_q};
                        default: ;
                    endcase
                end
                ST_MUL: begin
                    ac_q <= mul_ac;
                    mq_q <= mul_mq;
                end
                ST_DIV: begin
                    if (first_step && div_ovf) begin
                        link_q <= 1'b1;
                    end else begin
                        ac_q <= div_ac;
                        mq_q <= div_mq;
                        if (first_step) link_q <= 1'b0;
                    end
                end
                ST_NORM: begin
                    if (!norm_stop) begin
                        {ac_q, mq_q} <= shl_pair;
                        sc_q         <= sc_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    case (cmd_r)
                        OP_SHL:  {ac_q, mq_q} <= shl_pair;
                        OP_ASR:  {ac_q, mq_q} <= asr_pair;
                        default: {ac_q, mq_q} <= lsr_pair;
                    endcase
                    if (sc_q != '0) sc_q <= sc_q - 1'b1;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        ac     = ac_q;
        mq     = mq_q;
        link   = link_q;
        sc     = sc_q;
        cmd_q  = cmd_r;
        opnd_q = opnd_r;
    end

endmodule

// File: rtl/mdn_unit.sv
module mdn_unit
    import mdn_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [OP_W-1:0] cmd,
    input  logic [W-1:0]  operand,
    output logic [W-1:0]  ac,
    output logic [W-1:0]  mq,
    output logic          link,
    output logic [SW-1:0] sc,
    output logic          done
);

    localparam int unsigned PW = 2 * W;

    st_e           st;
    logic          first_step;
    op_e           cmd_q;
    logic [W-1:0]  opnd_q;
    logic [W-1:0]  mul_ac;
    logic [W-1:0]  mul_mq;
    logic [W-1:0]  div_ac;
    logic [W-1:0]  div_mq;
    logic          div_ovf;
    logic [PW-1:0] shl_pair;
    logic [PW-1:0] asr_pair;
    logic [PW-1:0] lsr_pair;
    logic          norm_stop;
    logic          shift_last;
    op_e           cmd_in;

    assign cmd_in = op_e'(cmd);

    mdn_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd        (cmd_in),
        .div_ovf    (div_ovf),
        .norm_stop  (norm_stop),
        .shift_last (shift_last),
        .state      (st),
        .first_step (first_step),
        .done       (done)
    );

    mdn_alu #(.W(W), .SW(SW)) u_alu (
        .ac         (ac),
        .mq         (mq),
        .opnd       (opnd_q),
        .sc         (sc),
        .mul_ac     (mul_ac),
        .mul_mq     (mul_mq),
        .div_ac     (div_ac),
        .div_mq     (div_mq),
        .div_ovf    (div_ovf),
        .shl_pair   (shl_pair),
        .asr_pair   (asr_pair),
        .lsr_pair   (lsr_pair),
        .norm_stop  (norm_stop),
        .shift_last (shift_last)
    );

    mdn_regs #(.W(W), .SW(SW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd        (cmd_in),
        .operand    (operand),
        .state      (st),
        .first_step (first_step),
        .mul_ac     (mul_ac),
        .mul_mq     (mul_mq),
        .div_ac     (div_ac),
        .div_mq     (div_mq),
        .div_ovf    (div_ovf),
        .shl_pair   (shl_pair),
        .asr_pair   (asr_pair),
        .lsr_pair   (lsr_pair),
        .norm_stop  (norm_stop),
        .ac         (ac),
        .mq         (mq),
        .link       (link),
        .sc         (sc),
        .cmd_q      (cmd_q),
        .opnd_q     (opnd_q)
    );

endmodule

// File: rtl/mdn_chk.sv
module mdn_chk
    import mdn_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned SW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic [W-1:0]  ac,
    input logic [W-1:0]  mq,
    input logic          link,
    input logic [SW-1:0] sc,
    input st_e           st,
    input op_e           cmd_q,
    input logic [W-1:0]  opnd_q
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start) |=> ($stable(ac) && $stable(mq) && $stable(link) && $stable(sc))); // R12

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(cmd_q) && $stable(opnd_q))); // R11

    AST_MQL_CLEARS_AC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q == OP_MQL) |-> (ac == '0)); // R3

    AST_DIV_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q == OP_DIV && !link) |-> (ac < opnd_q)); // R5

    AST_DIV_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q == OP_DIV && link) |-> (ac >= opnd_q)); // R6

    AST_NORM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q == OP_NMI) |-> ((ac[W-1] != ac[W-2]) || (ac == '0 && mq == '0))); // R7

    AST_NORM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q == OP_NMI) |-> !link); // R8

    AST_SHIFT_SC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cmd_q == OP_SHL || cmd_q == OP_ASR || cmd_q == OP_LSR)) |-> (sc == '0)); // R9

    AST_SHIFT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT) |=> $stable(link)); // R10

endmodule

bind mdn_unit mdn_chk #(.W(W), .SW(SW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .ac     (ac),
    .mq     (mq),
    .link   (link),
    .sc     (sc),
    .st     (st),
    .cmd_q  (cmd_q),
    .opnd_q (opnd_q)
);

// File: tb/sim_mdn_unit.sv
module sim_mdn_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cmd = 4'd0;
    logic [11:0] operand = 12'd0;
    logic [11:0] ac;
    logic [11:0] mq;
    logic        link;
    logic [4:0]  sc;
    logic        done;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    mdn_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmd     (cmd),
        .operand (operand),
        .ac      (ac),
        .mq      (mq),
        .link    (link),
        .sc      (sc),
        .done    (done)
    );

    // {req 4, cmd 4, operand 12, ac 12, mq 12, link 1, sc 5, latency 6}
    localparam int NV = 27;
    localparam logic [55:0] TBL [NV] = '{
        {4'd2,  4'h0, 12'h123, 12'h123, 12'h000, 1'b0, 5'd0,  6'd1 },  // R2 load AC
        {4'd3,  4'h1, 12'h000, 12'h000, 12'h123, 1'b0, 5'd0,  6'd1 },  // R3 AC to MQ
        {4'd4,  4'h4, 12'h456, 12'h04E, 12'hDC2, 1'b0, 5'd0,  6'd12},  // R4 123*456
        {4'd2,  4'h0, 12'hFFF, 12'hFFF, 12'hDC2, 1'b0, 5'd0,  6'd1 },  // R2
        {4'd3,  4'h1, 12'h000, 12'h000, 12'hFFF, 1'b0, 5'd0,  6'd1 },  // R3
        {4'd4,  4'h4, 12'hFFF, 12'hFFE, 12'h001, 1'b0, 5'd0,  6'd12},  // R4 largest product
        {4'd5,  4'h5, 12'hFFF, 12'h000, 12'hFFF, 1'b0, 5'd0,  6'd12},  // R5 exact divide
        {4'd5,  4'h5, 12'h010, 12'h00F, 12'h0FF, 1'b0, 5'd0,  6'd12},  // R5 with remainder
        {4'd6,  4'h5, 12'h00F, 12'h00F, 12'h0FF, 1'b1, 5'd0,  6'd1 },  // R6 AC equals divisor
        {4'd6,  4'h5, 12'h000, 12'h00F, 12'h0FF, 1'b1, 5'd0,  6'd1 },  // R6 zero divisor
        {4'd9,  4'h7, 12'h000, 12'h01E, 12'h1FE, 1'b1, 5'd0,  6'd1 },  // R9 one place, link kept
        {4'd9,  4'h7, 12'h003, 12'h1E1, 12'hFE0, 1'b1, 5'd0,  6'd4 },  // R9 four places
        {4'd2,  4'h0, 12'h800, 12'h800, 12'hFE0, 1'b1, 5'd0,  6'd1 },  // R2
        {4'd10, 4'h8, 12'h001, 12'hE00, 12'h3F8, 1'b1, 5'd0,  6'd2 },  // R10 sign fill
        {4'd10, 4'h9, 12'h001, 12'h380, 12'h0FE, 1'b1, 5'd0,  6'd2 },  // R10 zero fill
        {4'd9,  4'h8, 12'hFFF, 12'h000, 12'h000, 1'b1, 5'd0,  6'd32},  // R9 only low 5 count bits
        {4'd8,  4'h6, 12'h000, 12'h000, 12'h000, 1'b0, 5'd0,  6'd1 },  // R8 zero pair
        {4'd2,  4'h0, 12'h001, 12'h001, 12'h000, 1'b0, 5'd0,  6'd1 },  // R2
        {4'd7,  4'h6, 12'h000, 12'h400, 12'h000, 1'b0, 5'd10, 6'd11},  // R7 ten shifts
        {4'd2,  4'h3, 12'h000, 12'h00A, 12'h000, 1'b0, 5'd10, 6'd1 },  // R2 counter to AC
        {4'd2,  4'h0, 12'hABC, 12'hABC, 12'h000, 1'b0, 5'd10, 6'd1 },  // R2
        {4'd3,  4'h1, 12'h000, 12'h000, 12'hABC, 1'b0, 5'd10, 6'd1 },  // R3
        {4'd2,  4'h2, 12'h000, 12'hABC, 12'hABC, 1'b0, 5'd10, 6'd1 },  // R2 MQ to AC
        {4'd2,  4'h0, 12'hF00, 12'hF00, 12'hABC, 1'b0, 5'd10, 6'd1 },  // R2
        {4'd7,  4'h6, 12'h000, 12'h805, 12'h5E0, 1'b0, 5'd3,  6'd4 },  // R7 negative value
        {4'd10, 4'h9, 12'h000, 12'h402, 12'hAF0, 1'b0, 5'd0,  6'd1 },  // R10 counter back to 0
        {4'd12, 4'hC, 12'h777, 12'h402, 12'hAF0, 1'b0, 5'd0,  6'd1 }   // R12 unknown code
    };

    task automatic check(input int r, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", r, what, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [11:0] o, output int lat);
        @(negedge clk);
        cmd = c; operand = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
        finished = 1'b1;
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired, run hung");
            finish_run();
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        check(1, "ac in reset", {20'd0, ac}, 32'd0);
        check(1, "done in reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "pair after reset", {8'd0, ac, mq}, 32'd0);
        check(1, "link/sc after reset", {26'd0, link, sc}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [55:0] v;
            int r;
            v = TBL[i];
            r = int'(v[55:52]);
            issue(v[51:48], v[47:36], lat);
            check(r, $sformatf("row %0d latency", i), lat, {26'd0, v[5:0]});
            check(r, $sformatf("row %0d ac", i), {20'd0, ac}, {20'd0, v[35:24]});
            check(r, $sformatf("row %0d mq", i), {20'd0, mq}, {20'd0, v[23:12]});
            check(r, $sformatf("row %0d link", i), {31'd0, link}, {31'd0, v[11]});
            check(r, $sformatf("row %0d sc", i), {27'd0, sc}, {27'd0, v[10:6]});
            @(negedge clk);
            check(12, $sformatf("row %0d done width", i), {31'd0, done}, 32'd0);
        end

        // R11: start with a load command while a multiply runs
        // state: ac=402 mq=AF0; AF0 * 002 = 0015E0
        @(negedge clk);
        cmd = 4'h4; operand = 12'h002; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (lat == 3) begin
                cmd = 4'h0; operand = 12'h555; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(11, "busy start latency", lat, 32'd12);
        check(11, "busy start product", {8'd0, ac, mq}, 32'h0015E0);
        repeat (4) @(negedge clk);
        check(11, "no second command", {8'd0, ac, mq}, 32'h0015E0);
        check(12, "idle holds link/sc", {26'd0, link, sc}, 32'd0);

        // R1: reset in the middle of a divide
        @(negedge clk);
        cmd = 4'h5; operand = 12'h003; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, "mid-run reset pair", {8'd0, ac, mq}, 32'd0);
        check(1, "mid-run reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(1, "no resumed command", {26'd0, link, sc}, 32'd0);
        check(1, "no resumed pair", {8'd0, ac, mq}, 32'd0);

        finish_run();
    end

endmodule